// File: doc/BRIEF.md
# Victim Retention Decision Engine

This block sits beside the controller of one last-level cache bank. When a set evicts its least recently used line, the block decides whether that victim is kept in a lightly used set of the same bank or dropped, and which set receives it. Per-set miss pressures come from a separate tracker as one flat vector. From these the block derives the global minimum and maximum and two thresholds: a low limit `min + delta` and a high limit `max - delta`, where `delta = ((max - min) * ANUM) >> ASH`. The fraction `ANUM / 2^ASH` must not exceed one half.

A table holds P destination pointers for every set, and each pointer is either valid or free. A source first tries the sets it already points at. Only when none of them is light enough does it claim a free pointer for the set with the lowest global pressure. Many sources may point at one destination, and one source may point at many destinations.

The cache tells the block when the last retained line from source `j` leaves destination `D`. The block then frees the pointer in entry `j` that names `D`. Moving the data and inserting the kept line at the most recently used position are the job of the cache datapath. That datapath also drops the destination's own victim without further retention.

Top module: `vret_engine`

## Requirements
- R1: While reset is asserted, `done_o`, `retain_o` and `dest_o` are 0 and every pointer of every table entry is free.
- R2: A request on `req_i` gives a one-cycle `done_o` pulse on the next clock. `retain_o` and `dest_o` change only in that cycle and hold their values until the next pulse. On a discard, `dest_o` is 0.
- R3: A victim is retained only when its source set's pressure is strictly greater than the high limit.
- R4: An eligible source with no valid pointer retains at the global-minimum set only if that minimum is strictly below the low limit. The lowest-numbered free pointer of the source entry is then set to that set.
- R5: An eligible source with valid pointers takes the pointed-to set of lowest pressure (ties go to the lowest pointer number) if that pressure is strictly below the low limit. No pointer changes in this case.
- R6: When no pointed-to set qualifies, the victim goes to the global-minimum set through the lowest free pointer, provided a pointer is free and the minimum is below the low limit. Otherwise the victim is discarded.
- R7: A victim flagged as previously retained (`req_retained_i` = 1) is discarded when `req_sharers_i` is all zero. With any sharer bit set, it is handled like a native line.
- R8: A release with `rel_last_i` = 1 frees the pointer in entry `rel_src_i` that names `rel_dest_i`. A release with `rel_last_i` = 0 leaves the table unchanged.
- R9: When several sets share the global minimum pressure, the lowest set index is the global-minimum set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| press_i | input | NSETS*PW | Pressure of set k in bits [k*PW +: PW] |
| req_i | input | 1 | Eviction decision request |
| req_set_i | input | SW | Source set of the victim |
| req_retained_i | input | 1 | Victim was itself a retained line |
| req_sharers_i | input | NCORES | Directory sharer vector of the victim |
| rel_i | input | 1 | A retained line left a destination set |
| rel_src_i | input | SW | Source index carried by the leaving line |
| rel_dest_i | input | SW | Destination set the line left |
| rel_last_i | input | 1 | No other line in the destination carries that source index |
| done_o | output | 1 | Decision pulse |
| retain_o | output | 1 | Victim is to be kept |
| dest_o | output | SW | Destination set for a kept victim |

## Verification
The hardest state to reach is a source entry whose pointers are all valid, none of whose targets is light enough, while a light set elsewhere is left unused. The stimulus fills both pointers of one source by moving the global minimum between two requests. It then raises both pointed-to sets above the low limit, so the request is discarded. A release without the last flag must keep that discard. The release with the flag must let the next request take the freed pointer.

// File: rtl/vret_pkg.sv
package vret_pkg;
    typedef enum logic [1:0] {
        PATH_DROP  = 2'd0,
        PATH_REUSE = 2'd1,
        PATH_ALLOC = 2'd2
    } path_e;
endpackage

// File: rtl/vret_limits.sv
module vret_limits #(
    parameter int NSETS = 16,
    parameter int PW    = 8,
    parameter int ANUM  = 1,
    parameter int ASH   = 2,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic [NSETS*PW-1:0] press_i,
    output logic [PW-1:0]       gmin_o,
    output logic [SW-1:0]       gmin_idx_o,
    output logic [PW-1:0]       low_o,
    output logic [PW-1:0]       high_o
);
    localparam int XW = PW + 16;

    logic [PW-1:0] mn, mx, v;
    logic [SW-1:0] idx;
    logic [XW-1:0] prod;
    logic [PW-1:0] delta;

    always_comb begin
        mn  = press_i[PW-1:0];
        mx  = press_i[PW-1:0];
        idx = '0;
        v   = '0;
        for (int i = 1; i < NSETS; i++) begin
            v = press_i[i*PW +: PW];
            if (v < mn) begin
                mn  = v;
                idx = SW'(i);
            end
            if (v > mx) mx = v;
        end
        prod  = XW'(mx - mn) * XW'(ANUM);
        delta = PW'(prod >> ASH);
    end

    assign gmin_o     = mn;
    assign gmin_idx_o = idx;
    assign low_o      = mn + delta;
    assign high_o     = mx - delta;
endmodule

// File: rtl/vret_pick.sv
module vret_pick #(
    parameter int NSETS = 16,
    parameter int PW    = 8,
    parameter int P     = 2,
    localparam int SW   = $clog2(NSETS),
    localparam int PSW  = (P > 1) ? $clog2(P) : 1
) (
    input  logic [P-1:0]        vld_i,
    input  logic [P*SW-1:0]     dst_i,
    input  logic [NSETS*PW-1:0] press_i,
    output logic                any_o,
    output logic [PW-1:0]       best_val_o,
    output logic [SW-1:0]       best_dst_o,
    output logic                free_o,
    output logic [PSW-1:0]      free_slot_o
);
    logic [SW-1:0] d;
    logic [PW-1:0] pv;

    always_comb begin
        any_o       = 1'b0;
        best_val_o  = '1;
        best_dst_o  = '0;
        free_o      = 1'b0;
        free_slot_o = '0;
        d           = '0;
        pv          = '0;
        for (int k = 0; k < P; k++) begin
            d  = dst_i[k*SW +: SW];
            pv = press_i[int'(d)*PW +: PW];
            if (vld_i[k] && (!any_o || pv < best_val_o)) begin
                any_o      = 1'b1;
                best_val_o = pv;
                best_dst_o = d;
            end
            if (!vld_i[k] && !free_o) begin
                free_o      = 1'b1;
                free_slot_o = PSW'(k);
            end
        end
    end
endmodule

// File: rtl/vret_engine.sv
module vret_engine #(
    parameter int NSETS  = 16,
    parameter int PW     = 8,
    parameter int P      = 2,
    parameter int NCORES = 8,
    parameter int ANUM   = 1,
    parameter int ASH    = 2,
    localparam int SW    = $clog2(NSETS),
    localparam int PSW   = (P > 1) ? $clog2(P) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSETS*PW-1:0] press_i,
    input  logic                req_i,
    input  logic [SW-1:0]       req_set_i,
    input  logic                req_retained_i,
    input  logic [NCORES-1:0]   req_sharers_i,
    input  logic                rel_i,
    input  logic [SW-1:0]       rel_src_i,
    input  logic [SW-1:0]       rel_dest_i,
    input  logic                rel_last_i,
    output logic                done_o,
    output logic                retain_o,
    output logic [SW-1:0]       dest_o
);
    import vret_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] dst;
    } ptr_t;

    typedef struct packed {
        ptr_t [NSETS-1:0][P-1:0] tbl;
        logic                    done;
        logic                    keep;
        logic [SW-1:0]           dst;
    } state_t;

    state_t st_q, st_d;

    logic [PW-1:0]  gmin, lowl, highl, srcp, bval;
    logic [SW-1:0]  gmin_idx, bdst;
    logic [P-1:0]   row_vld;
    logic [P*SW-1:0] row_dst;
    logic           any_vld, has_free, eligible;
    logic [PSW-1:0] free_slot;
    path_e          path;

    vret_limits #(.NSETS(NSETS), .PW(PW), .ANUM(ANUM), .ASH(ASH)) u_limits (
        .press_i    (press_i),
        .gmin_o     (gmin),
        .gmin_idx_o (gmin_idx),
        .low_o      (lowl),
        .high_o     (highl)
    );

    for (genvar k = 0; k < P; k++) begin : g_row
        assign row_vld[k]           = st_q.tbl[req_set_i][k].vld;
        assign row_dst[k*SW +: SW]  = st_q.tbl[req_set_i][k].dst;
    end

    vret_pick #(.NSETS(NSETS), .PW(PW), .P(P)) u_pick (
        .vld_i       (row_vld),
        .dst_i       (row_dst),
        .press_i     (press_i),
        .any_o       (any_vld),
        .best_val_o  (bval),
        .best_dst_o  (bdst),
        .free_o      (has_free),
        .free_slot_o (free_slot)
    );

    assign srcp     = press_i[int'(req_set_i)*PW +: PW];
    assign eligible = (srcp > highl) && (!req_retained_i || (|req_sharers_i));

    always_comb begin
        path = PATH_DROP;
        if (eligible) begin
            if (any_vld && bval < lowl)       path = PATH_REUSE;
            else if (has_free && gmin < lowl) path = PATH_ALLOC;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (rel_i && rel_last_i) begin
            for (int k = 0; k < P; k++) begin
                if (st_q.tbl[rel_src_i][k].vld && st_q.tbl[rel_src_i][k].dst == rel_dest_i)
                    st_d.tbl[rel_src_i][k].vld = 1'b0;
            end
        end
        if (req_i) begin
            st_d.done = 1'b1;
            case (path)
                PATH_REUSE: begin
                    st_d.keep = 1'b1;
                    st_d.dst  = bdst;
                end
                PATH_ALLOC: begin
                    st_d.keep = 1'b1;
                    st_d.dst  = gmin_idx;
                    st_d.tbl[req_set_i][free_slot].vld = 1'b1;
                    st_d.tbl[req_set_i][free_slot].dst = gmin_idx;
                end
                default: begin
                    st_d.keep = 1'b0;
                    st_d.dst  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign retain_o = st_q.keep;
    assign dest_o   = st_q.dst;
endmodule

// File: rtl/vret_engine_chk.sv
module vret_engine_chk #(
    parameter int NSETS  = 16,
    parameter int PW     = 8,
    parameter int NCORES = 8,
    localparam int SW    = $clog2(NSETS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NSETS*PW-1:0] press_i,
    input logic                req_i,
    input logic [SW-1:0]       req_set_i,
    input logic                req_retained_i,
    input logic [NCORES-1:0]   req_sharers_i,
    input logic                done_o,
    input logic                retain_o,
    input logic [SW-1:0]       dest_o
);
    function automatic logic [PW-1:0] at(input logic [NSETS*PW-1:0] f, input logic [SW-1:0] i);
        return f[int'(i)*PW +: PW];
    endfunction

    // R2: pulse follows a request by one clock
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i) |-> done_o);

    // R2: without a request the decision is held
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> (!done_o && $stable(retain_o) && $stable(dest_o)));

    // R3: a kept victim goes to a set lighter than its source
    assert_lighter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && retain_o) |-> (at($past(press_i), $past(req_set_i)) > at($past(press_i), dest_o)));

    // R4: a victim never returns to its own set
    assert_not_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && retain_o) |-> (dest_o != $past(req_set_i)));

    // R7: stale retained victims are dropped
    assert_stale_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(req_retained_i) && ($past(req_sharers_i) == '0)) |-> !retain_o);
endmodule

bind vret_engine vret_engine_chk #(.NSETS(NSETS), .PW(PW), .NCORES(NCORES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .press_i        (press_i),
    .req_i          (req_i),
    .req_set_i      (req_set_i),
    .req_retained_i (req_retained_i),
    .req_sharers_i  (req_sharers_i),
    .done_o         (done_o),
    .retain_o       (retain_o),
    .dest_o         (dest_o)
);

// File: tb/vret_engine_tb.sv
`timescale 1ns/1ps
module vret_engine_tb;
    localparam int NSETS = 16, PW = 8, P = 2, NCORES = 8, ANUM = 1, ASH = 2;
    localparam int SW = $clog2(NSETS);

    logic clk = 0, rst_n = 0;
    logic [NSETS*PW-1:0] press_i = '0;
    logic req_i = 0, req_retained_i = 0;
    logic [SW-1:0] req_set_i = '0;
    logic [NCORES-1:0] req_sharers_i = '0;
    logic rel_i = 0, rel_last_i = 0;
    logic [SW-1:0] rel_src_i = '0, rel_dest_i = '0;
    logic done_o, retain_o;
    logic [SW-1:0] dest_o;

    always #10 clk = ~clk;

    vret_engine #(.NSETS(NSETS), .PW(PW), .P(P), .NCORES(NCORES), .ANUM(ANUM), .ASH(ASH)) u_dut (
        .clk(clk), .rst_n(rst_n), .press_i(press_i), .req_i(req_i), .req_set_i(req_set_i),
        .req_retained_i(req_retained_i), .req_sharers_i(req_sharers_i), .rel_i(rel_i),
        .rel_src_i(rel_src_i), .rel_dest_i(rel_dest_i), .rel_last_i(rel_last_i),
        .done_o(done_o), .retain_o(retain_o), .dest_o(dest_o));

    int checks = 0, fails = 0;

    // behavioural reference
    bit mv[NSETS][P];
    int md[NSETS][P];
    bit exp_done = 0, exp_keep = 0;
    int exp_dest = 0;
    string exp_tag = "R2";
    bit rel_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mv[i, k]) begin mv[i][k] = 0; md[i][k] = 0; end
            exp_done = 0; exp_keep = 0; exp_dest = 0; exp_tag = "R1"; rel_seen = 0;
        end else begin
            int p[NSETS];
            int mn, mni, mx, delta, lo, hi, nmin, best, bslot, fslot, s;
            bit elig, stale;
            string tag;
            int alloc_slot;
            alloc_slot = -1;
            if (req_i) begin
                for (int i = 0; i < NSETS; i++) p[i] = int'(press_i[i*PW +: PW]);
                mn = p[0]; mni = 0; mx = p[0];
                for (int i = 1; i < NSETS; i++) begin
                    if (p[i] < mn) begin mn = p[i]; mni = i; end
                    if (p[i] > mx) mx = p[i];
                end
                nmin = 0;
                for (int i = 0; i < NSETS; i++) if (p[i] == mn) nmin++;
                delta = ((mx - mn) * ANUM) >> ASH;
                lo = mn + delta; hi = mx - delta;
                s = int'(req_set_i);
                stale = req_retained_i && (req_sharers_i == 0);
                elig = (p[s] > hi) && !stale;
                best = -1; bslot = -1; fslot = -1;
                for (int k = 0; k < P; k++) begin
                    if (mv[s][k] && (best < 0 || p[md[s][k]] < best)) begin best = p[md[s][k]]; bslot = k; end
                    if (!mv[s][k] && fslot < 0) fslot = k;
                end
                exp_done = 1;
                if (stale) begin tag = "R7"; exp_keep = 0; exp_dest = 0; end
                else if (!elig) begin tag = "R3"; exp_keep = 0; exp_dest = 0; end
                else if (bslot >= 0 && best < lo) begin tag = "R5"; exp_keep = 1; exp_dest = md[s][bslot]; end
                else if (fslot >= 0 && mn < lo) begin
                    tag = (bslot >= 0) ? "R6" : "R4";
                    if (nmin > 1) tag = "R9";
                    exp_keep = 1; exp_dest = mni; alloc_slot = fslot;
                end else begin tag = (bslot >= 0) ? "R6" : "R4"; exp_keep = 0; exp_dest = 0; end
                if (rel_seen) begin tag = "R8"; rel_seen = 0; end
                exp_tag = tag;
            end else begin
                exp_done = 0;
                exp_tag = "R2";
            end
            if (rel_i) begin
                rel_seen = 1;
                if (rel_last_i)
                    for (int k = 0; k < P; k++)
                        if (mv[rel_src_i][k] && md[rel_src_i][k] == int'(rel_dest_i)) mv[rel_src_i][k] = 0;
            end
            if (alloc_slot >= 0) begin
                mv[req_set_i][alloc_slot] = 1;
                md[req_set_i][alloc_slot] = exp_dest;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", "done", int'(done_o), 0);
            chk("R1", "retain", int'(retain_o), 0);
            chk("R1", "dest", int'(dest_o), 0);
        end else begin
            chk("R2", "done", int'(done_o), int'(exp_done));
            chk(exp_tag, "retain", int'(retain_o), int'(exp_keep));
            chk(exp_tag, "dest", int'(dest_o), exp_dest);
        end
    end

    task automatic all_p(int v);
        for (int i = 0; i < NSETS; i++) press_i[i*PW +: PW] = PW'(v);
    endtask
    task automatic set_p(int i, int v);
        press_i[i*PW +: PW] = PW'(v);
    endtask
    task automatic do_req(int s, bit ret, int sh);
        @(negedge clk);
        req_i = 1; req_set_i = SW'(s); req_retained_i = ret; req_sharers_i = NCORES'(sh);
        @(negedge clk);
        req_i = 0; req_retained_i = 0; req_sharers_i = '0;
        repeat (2) @(negedge clk);
    endtask
    task automatic do_rel(int s, int d, bit last);
        @(negedge clk);
        rel_i = 1; rel_src_i = SW'(s); rel_dest_i = SW'(d); rel_last_i = last;
        @(negedge clk);
        rel_i = 0; rel_last_i = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R3: source exactly at high limit, then one above
        all_p(100); set_p(0, 10); set_p(5, 200); set_p(3, 153);
        do_req(3, 0, 0);
        set_p(3, 154);
        do_req(3, 0, 0);
        set_p(3, 100);
        // R4: first allocation for source 5
        do_req(5, 0, 0);
        // R5: reuse existing pointer
        set_p(0, 40);
        do_req(5, 0, 0);
        // R6: pointed set too heavy, fall back to a new pointer
        set_p(0, 90); set_p(7, 20);
        do_req(5, 0, 0);
        // R6: both pointers busy and too heavy -> drop
        set_p(7, 90); set_p(9, 15);
        do_req(5, 0, 0);
        // R5: lightest pointed-to set
        set_p(7, 30);
        do_req(5, 0, 0);
        // R5: tie among pointers goes to lower slot
        set_p(0, 30);
        do_req(5, 0, 0);
        // R8: release without last flag keeps table, with flag frees slot
        set_p(0, 90); set_p(7, 90);
        do_rel(5, 0, 0);
        do_req(5, 0, 0);
        do_rel(5, 0, 1);
        do_req(5, 0, 0);
        // R7: stale retained victim, then one still shared
        do_req(5, 1, 0);
        do_req(5, 1, 8'h04);
        // R9: tie on the global minimum
        all_p(100); set_p(12, 200); set_p(11, 10); set_p(3, 10);
        do_req(12, 0, 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule